// File: doc/BRIEF.md
# Fast Ethernet MII Transmit Line Encoder

This block turns the nibble stream a MAC offers on the transmit half of an MII into the serial, three-level line stream of a 100 Mb/s twisted-pair link. It runs in a single 125 MHz bit-clock domain and brings out a one-cycle nibble strobe, one cycle in five, that stands in for the 25 MHz transfer clock. The MAC presents `txd`, `tx_en` and `tx_er`, and the block samples them on the clock edge that ends a strobe cycle.

Each sampled nibble becomes a 5-bit code group. The framer opens each frame with a start-delimiter pair and closes it with an end-delimiter pair. It sends the idle group between frames and the error group when the MAC flags a bad nibble. The group is shifted out most significant bit first and XORed with a free-running 11-bit scrambler sequence. The result is then driven as an MLT-3 symbol, given as a 2-bit two's-complement level.

Top module: `mii_tx_encoder`

## Requirements
- R1: `nib_stb` is high for exactly one cycle in every five. It is high in the first cycle after reset release, and the inputs are sampled on the rising edge at the end of each cycle in which it is high.
- R2: Outside a frame, a sample with `tx_en` low yields the idle group 11111, whatever `txd` and `tx_er` carry.
- R3: The first two samples with `tx_en` high yield the start pair 11000 then 10001, whatever `txd` and `tx_er` carry.
- R4: Each later sample with `tx_en` high and `tx_er` low yields the 4B5B code of `txd`. For nibble values 0 through F these are 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100 and 11101.
- R5: A data sample with both `tx_en` and `tx_er` high yields the error group 00100 in place of the nibble's code.
- R6: The first sample with `tx_en` low after a frame has begun yields 01101. The next sample yields 00111 whatever the inputs carry, and the state then returns to idle. A frame of one nibble therefore gives 11000, 01101, 00111.
- R7: A code group sampled at edge E is sent MSB-first, one bit per clock. Its first bit reaches the line at edge E+1 and its last at edge E+5.
- R8: Each line bit is the code bit XORed with a key from an 11-bit register s (polynomial x^11 + x^9 + 1). The key is s[10]^s[8]. Every clock, s shifts left with the key entering at bit 0. Reset loads all ones into s.
- R9: On each 1 bit the line level advances one step through the cycle 0, +1, 0, -1. On each 0 bit it holds. The level is encoded 00 = 0, 01 = +1, 11 = -1, and 10 never appears.
- R10: While reset is held, `line_lvl` is 0 and `nib_stb` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txd | input | 4 | Nibble data from the MAC |
| tx_en | input | 1 | Frame-in-progress qualifier from the MAC |
| tx_er | input | 1 | Nibble error flag from the MAC |
| nib_stb | output | 1 | Nibble sample strobe, one cycle in five |
| line_lvl | output | 2 | Signed MLT-3 line level |

## Verification
A nibble sampled at a strobe edge has its five line symbols settled one to five clocks later. The bench therefore sends its stimulus at the falling edge before each strobe edge and queues the code group it predicts. It then reads the line at every falling edge. It recovers each bit from level changes, removes the key using its own scrambler model, and compares the group after the fifth bit. The strobe pattern and the legality of each level step are checked on every cycle.

// File: rtl/mtx_pkg.sv
package mtx_pkg;

  localparam int NIB_W = 4;
  localparam int GRP_W = 5;

  localparam logic [GRP_W-1:0] C_IDLE  = 5'b11111;
  localparam logic [GRP_W-1:0] C_SSD1  = 5'b11000;
  localparam logic [GRP_W-1:0] C_SSD2  = 5'b10001;
  localparam logic [GRP_W-1:0] C_ESD1  = 5'b01101;
  localparam logic [GRP_W-1:0] C_ESD2  = 5'b00111;
  localparam logic [GRP_W-1:0] C_HALT  = 5'b00100;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_SSD2 = 2'd1,
    FS_DATA = 2'd2,
    FS_ESD2 = 2'd3
  } frame_st_e;

  // 4B5B data code groups
  function automatic logic [GRP_W-1:0] nib_to_code(input logic [NIB_W-1:0] n);
    logic [GRP_W-1:0] c;
    case (n)
      4'h0: c = 5'b11110;
      4'h1: c = 5'b01001;
      4'h2: c = 5'b10100;
      4'h3: c = 5'b10101;
      4'h4: c = 5'b01010;
      4'h5: c = 5'b01011;
      4'h6: c = 5'b01110;
      4'h7: c = 5'b01111;
      4'h8: c = 5'b10010;
      4'h9: c = 5'b10011;
      4'hA: c = 5'b10110;
      4'hB: c = 5'b10111;
      4'hC: c = 5'b11010;
      4'hD: c = 5'b11011;
      4'hE: c = 5'b11100;
      default: c = 5'b11101;
    endcase
    return c;
  endfunction

  // MLT-3 phase to signed level: 0, +1, 0, -1
  function automatic logic signed [1:0] mlt_level(input logic [1:0] ph);
    logic signed [1:0] l;
    case (ph)
      2'd1:    l = 2'sb01;
      2'd3:    l = 2'sb11;
      default: l = 2'sb00;
    endcase
    return l;
  endfunction

endpackage

// File: rtl/mtx_cadence.sv
module mtx_cadence #(
  parameter int DIV = 5
) (
  input  logic clk,
  input  logic rst_n,
  output logic stb
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign stb = (cnt_q == '0);
endmodule

// File: rtl/mtx_framer.sv
module mtx_framer
  import mtx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb,
  input  logic [NIB_W-1:0] txd,
  input  logic             tx_en,
  input  logic             tx_er,
  output logic [GRP_W-1:0] grp,
  output logic             in_frame,
  output logic             data_phase
);
  frame_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    grp  = C_IDLE;
    case (st_q)
      FS_IDLE: begin
        if (tx_en) begin
          grp  = C_SSD1;
          st_d = FS_SSD2;
        end
      end
      FS_SSD2: begin
        if (tx_en) begin
          grp  = C_SSD2;
          st_d = FS_DATA;
        end else begin
          grp  = C_ESD1;
          st_d = FS_ESD2;
        end
      end
      FS_DATA: begin
        if (tx_en) begin
          grp  = tx_er ? C_HALT : nib_to_code(txd);
        end else begin
          grp  = C_ESD1;
          st_d = FS_ESD2;
        end
      end
      default: begin
        grp  = C_ESD2;
        st_d = FS_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   st_q <= FS_IDLE;
    else if (stb) st_q <= st_d;
  end

  assign in_frame   = (st_q != FS_IDLE);
  assign data_phase = (st_q == FS_DATA);
endmodule

// File: rtl/mtx_scrambler.sv
module mtx_scrambler #(
  parameter int GW   = 5,
  parameter int LW   = 11,
  parameter int TAP  = 9,
  parameter logic [LW-1:0] SEED = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb,
  input  logic [GW-1:0] grp,
  output logic          code_bit,
  output logic          line_bit
);
  function automatic logic key_of(input logic [LW-1:0] s);
    return s[LW-1] ^ s[TAP-1];
  endfunction

  function automatic logic [LW-1:0] lfsr_step(input logic [LW-1:0] s);
    return {s[LW-2:0], key_of(s)};
  endfunction

  logic [GW-1:0] sh_q;
  logic [LW-1:0] lf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sh_q <= '1;
    else if (stb) sh_q <= grp;
    else          sh_q <= {sh_q[GW-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lf_q <= SEED;
    else        lf_q <= lfsr_step(lf_q);
  end

  assign code_bit = sh_q[GW-1];
  assign line_bit = code_bit ^ key_of(lf_q);
endmodule

// File: rtl/mtx_mlt3.sv
module mtx_mlt3
  import mtx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_in,
  output logic signed [1:0] lvl
);
  logic [1:0] ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ph_q <= 2'd0;
    else if (bit_in) ph_q <= ph_q + 2'd1;
  end

  assign lvl = mlt_level(ph_q);
endmodule

// File: rtl/mii_tx_encoder.sv
module mii_tx_encoder
  import mtx_pkg::*;
#(
  parameter int LFSR_W = 11,
  parameter int LFSR_TAP = 9,
  parameter logic [LFSR_W-1:0] LFSR_SEED = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        txd,
  input  logic              tx_en,
  input  logic              tx_er,
  output logic              nib_stb,
  output logic signed [1:0] line_lvl
);
  logic [GRP_W-1:0] grp;
  logic             in_frame;
  logic             data_phase;
  logic             code_bit;
  logic             line_bit;

  mtx_cadence #(.DIV(GRP_W)) u_cad (
    .clk   (clk),
    .rst_n (rst_n),
    .stb   (nib_stb)
  );

  mtx_framer u_frm (
    .clk        (clk),
    .rst_n      (rst_n),
    .stb        (nib_stb),
    .txd        (txd),
    .tx_en      (tx_en),
    .tx_er      (tx_er),
    .grp        (grp),
    .in_frame   (in_frame),
    .data_phase (data_phase)
  );

  mtx_scrambler #(
    .GW   (GRP_W),
    .LW   (LFSR_W),
    .TAP  (LFSR_TAP),
    .SEED (LFSR_SEED)
  ) u_scr (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb      (nib_stb),
    .grp      (grp),
    .code_bit (code_bit),
    .line_bit (line_bit)
  );

  mtx_mlt3 u_mlt (
    .clk    (clk),
    .rst_n  (rst_n),
    .bit_in (line_bit),
    .lvl    (line_lvl)
  );
endmodule

// File: rtl/mtx_checker.sv
module mtx_checker
  import mtx_pkg::*;
#(
  parameter int DIV = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stb,
  input logic              tx_en,
  input logic              tx_er,
  input logic [GRP_W-1:0]  grp,
  input logic              in_frame,
  input logic              data_phase,
  input logic signed [1:0] line_lvl
);
  localparam int GW = $clog2(DIV + 1);

  logic [GW-1:0] gap_q;
  logic          seen_q;
  logic          esd1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
      esd1_q <= 1'b0;
    end else if (stb) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
      esd1_q <= (grp == C_ESD1);
    end else begin
      gap_q  <= gap_q + 1'b1;
    end
  end

  a_r1_stb_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && seen_q) |-> (gap_q == GW'(DIV - 1)));

  a_r2_idle_outside: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && !tx_en && !in_frame) |-> (grp == C_IDLE));

  a_r5_error_group: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && tx_en && tx_er && data_phase) |-> (grp == C_HALT));

  a_r6_esd_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && esd1_q) |-> (grp == C_ESD2));

  a_r9_level_legal: assert property (@(posedge clk) disable iff (!rst_n)
    line_lvl != 2'sb10);

  a_r9_adjacent_step: assert property (@(posedge clk) disable iff (!rst_n)
    (line_lvl != $past(line_lvl)) |-> (line_lvl == 2'sb00 || $past(line_lvl) == 2'sb00));
endmodule

bind mii_tx_encoder mtx_checker #(.DIV(mtx_pkg::GRP_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .stb        (nib_stb),
  .tx_en      (tx_en),
  .tx_er      (tx_er),
  .grp        (grp),
  .in_frame   (in_frame),
  .data_phase (data_phase),
  .line_lvl   (line_lvl)
);

// File: tb/mii_tx_encoder_tb.sv
module mii_tx_encoder_tb;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [3:0]        txd = 4'h0;
  logic              tx_en = 1'b0;
  logic              tx_er = 1'b0;
  logic              nib_stb;
  logic signed [1:0] line_lvl;

  int total = 0;
  int bad = 0;

  localparam int WD = 20000;
  localparam logic [79:0] TAB = {5'b11101,5'b11100,5'b11011,5'b11010,5'b10111,5'b10110,
                                 5'b10011,5'b10010,5'b01111,5'b01110,5'b01011,5'b01010,
                                 5'b10101,5'b10100,5'b01001,5'b11110};

  always #10 clk = ~clk;

  mii_tx_encoder u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .txd      (txd),
    .tx_en    (tx_en),
    .tx_er    (tx_er),
    .nib_stb  (nib_stb),
    .line_lvl (line_lvl)
  );

  logic [5:0] stim[$];
  logic [4:0] expq[$];
  int         bst = 0;

  task automatic add(input logic en, input logic er, input logic [3:0] d);
    stim.push_back({en, er, d});
  endtask

  function automatic logic [1:0] lvl_of(input int ph);
    case (ph & 3)
      1: return 2'b01;
      3: return 2'b11;
      default: return 2'b00;
    endcase
  endfunction

  // bench framer model: 0 idle, 1 second start, 2 data, 3 second end
  function automatic logic [4:0] expect_grp(input logic en, input logic er, input logic [3:0] d);
    logic [4:0] g;
    g = 5'b11111;
    case (bst)
      0: if (en) begin g = 5'b11000; bst = 1; end
      1: if (en) begin g = 5'b10001; bst = 2; end else begin g = 5'b01101; bst = 3; end
      2: if (en) g = er ? 5'b00100 : TAB[d*5 +: 5];
         else begin g = 5'b01101; bst = 3; end
      default: begin g = 5'b00111; bst = 0; end
    endcase
    return g;
  endfunction

  function automatic string tag_of(input logic [4:0] g);
    case (g)
      5'b11111: return "R2";
      5'b11000, 5'b10001: return "R3";
      5'b00100: return "R5";
      5'b01101, 5'b00111: return "R6";
      default: return "R4";
    endcase
  endfunction

  initial begin
    logic [10:0] bl;
    logic [1:0]  prev;
    logic [4:0]  rx;
    logic [4:0]  eg;
    logic [5:0]  s;
    logic        chg;
    logic        key;
    int          ph;
    int          k;
    int          tail;

    // idle with changing data and error: ignored (R2)
    add(0, 1, 4'h5); add(0, 0, 4'hA); add(0, 1, 4'hF);
    // frame: two preamble nibbles then all sixteen values (R3, R4)
    add(1, 0, 4'h5); add(1, 0, 4'h5);
    for (int i = 0; i < 16; i++) add(1, 0, 4'(i));
    add(0, 0, 4'h0); add(0, 1, 4'h3); add(0, 0, 4'h0);
    // error on a start nibble and on data nibbles (R3, R5)
    add(1, 1, 4'h5); add(1, 0, 4'h5); add(1, 0, 4'h2); add(1, 1, 4'h2); add(1, 1, 4'h9); add(1, 0, 4'hD);
    add(0, 0, 4'h0);
    // new frame requested during the second end group: ignored there (R6)
    add(1, 0, 4'h7); add(1, 0, 4'h5); add(1, 0, 4'h5); add(1, 0, 4'hC);
    add(0, 0, 4'h0); add(0, 1, 4'h1);
    // single-nibble frame (R6)
    add(1, 0, 4'h5); add(0, 0, 4'h0); add(0, 0, 4'h0); add(0, 0, 4'h0);
    // frame ending right after the start pair
    add(1, 0, 4'h5); add(1, 0, 4'h5); add(0, 0, 4'h0);

    // R10: reset state
    repeat (3) begin
      @(negedge clk);
      total++;
      if (line_lvl !== 2'sb00 || nib_stb !== 1'b1) begin
        bad++;
        $display("FAIL R10 reset: lvl=%b stb=%b exp lvl=00 stb=1", line_lvl, nib_stb);
      end
    end
    rst_n = 1'b1;
    expq.push_back(expect_grp(1'b0, 1'b0, 4'h0));
    bl = 11'h7FF; prev = 2'b00; ph = 0; rx = '0; k = 0; tail = 0;

    while ((stim.size() > 0 || tail < 6) && k < WD) begin
      @(negedge clk);
      k++;
      // R1: strobe cadence
      total++;
      if (nib_stb !== ((k % 5) == 0)) begin
        bad++;
        $display("FAIL R1 cycle %0d: stb=%b exp %b", k, nib_stb, (k % 5) == 0);
      end
      // R9: level legality and step order
      chg = (line_lvl !== prev);
      total++;
      if (chg && line_lvl !== lvl_of(ph + 1)) begin
        bad++;
        $display("FAIL R9 cycle %0d: lvl=%b exp %b", k, line_lvl, lvl_of(ph + 1));
      end
      if (chg) ph++;
      prev = line_lvl;
      // R7 R8: descramble and regroup the line bits
      key = bl[10] ^ bl[8];
      bl  = {bl[9:0], key};
      if (k >= 2) begin
        rx = {rx[3:0], chg ^ key};
        if (((k - 2) % 5) == 4) begin
          eg = expq.pop_front();
          total++;
          if (rx !== eg) begin
            bad++;
            $display("FAIL %s (R7 R8 path) cycle %0d: grp=%b exp %b", tag_of(eg), k, rx, eg);
          end
        end
      end
      if (nib_stb) begin
        if (stim.size() > 0) s = stim.pop_front();
        else begin s = 6'b0; tail++; end
        tx_en = s[5]; tx_er = s[4]; txd = s[3:0];
        expq.push_back(expect_grp(s[5], s[4], s[3:0]));
      end
    end
    if (k >= WD) begin
      total++;
      bad++;
      $display("FAIL watchdog: cycles=%0d exp < %0d", k, WD);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule